// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Control

This block is the purely combinational steering logic for a five-stage in-order pipeline. Its inputs are the source register numbers of the instructions in decode and execute, the destination numbers and write flags held in the two later pipeline registers, a flag that marks the instruction in execute as a load, and a taken-branch flag that decode computes. From these it picks the source of each ALU operand in execute, and it decides whether fetch and decode must hold still. It also decides whether the decode-to-execute register must take a bubble and whether the fetched instruction must be discarded.

When the instruction in execute reads a register that an older instruction has not yet written back, the newer copy of the value is bypassed to the ALU. If the instruction in execute is a load whose target is read by the instruction in decode, the block holds the program counter and the fetch/decode register for one cycle. During that cycle it asks for the control fields entering the decode/execute register to be cleared, which inserts a no-op. Branches are assumed not taken. When decode finds a branch taken, the block asks for the fetch/decode instruction field to be cleared.

The unit has no state, so it has no states or transitions. Each output follows its inputs within the same cycle.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: With no register match, no load in execute and no taken branch, both operand selects are 2'b00 (register file), pc_we and ifid_we are 1, and idex_bubble and ifid_flush are 0.
- R2: Operand select A (or B) is 2'b10 (take the execute/memory result) when exmem_we is 1, exmem_rd is nonzero and exmem_rd equals ex_rs (or ex_rt).
- R3: Operand select A (or B) is 2'b01 (take the memory/writeback result) when memwb_we is 1, memwb_rd is nonzero, memwb_rd equals the source, and R2 does not apply to that operand.
- R4: When both later stages match the same source, the select is 2'b10: the younger result wins.
- R5: Register number 0 never causes forwarding and never causes a stall, even when a write flag or the load flag is set.
- R6: A stage whose write flag is 0 never supplies a forwarded value, whatever its destination number.
- R7: When ex_is_load is 1, ex_rd is nonzero and ex_rd equals id_rs or id_rt, idex_bubble is 1 and both pc_we and ifid_we are 0. Otherwise idex_bubble is 0 and both enables are 1.
- R8: When id_br_taken is 1 and R7 requests no stall, ifid_flush is 1. With id_br_taken at 0, ifid_flush is 0.
- R9: When a stall and a taken branch occur together, the stall wins: ifid_flush is 0 and the bubble is raised.
- R10: The two operand selects are decided independently, each from its own source number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | REG_AW | First source register of the instruction in decode |
| id_rt | input | REG_AW | Second source register of the instruction in decode |
| ex_rs | input | REG_AW | First source register of the instruction in execute |
| ex_rt | input | REG_AW | Second source register of the instruction in execute |
| ex_rd | input | REG_AW | Destination register of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute reads data memory |
| exmem_rd | input | REG_AW | Destination held in the execute/memory register |
| exmem_we | input | 1 | Register-write flag in the execute/memory register |
| memwb_rd | input | REG_AW | Destination held in the memory/writeback register |
| memwb_we | input | 1 | Register-write flag in the memory/writeback register |
| id_br_taken | input | 1 | Branch resolved taken in decode |
| fwd_a | output | 2 | ALU operand A source: 00 regfile, 10 exec/mem, 01 mem/wb |
| fwd_b | output | 2 | ALU operand B source, same encoding |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Clear control fields entering decode/execute |
| ifid_flush | output | 1 | Clear the instruction field of fetch/decode |

## Verification
The unit holds no state, so any fault shows at the ports in the same cycle as the input pattern that exposes it. A wrong priority between the two bypass paths appears as a 2'b01 select where 2'b10 is expected, and only when both later stages target the same register. A missing register-0 guard shows up only when the input pattern uses register 0. A flush that is not suppressed during a stall appears only when a load-use hazard and a taken branch occur together. The random stimulus therefore draws register numbers from a small range, so that matches, register 0 and these combined cases occur often.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic [REG_AW-1:0] exmem_rd,
    input  logic              exmem_we,
    input  logic [REG_AW-1:0] memwb_rd,
    input  logic              memwb_we,
    output fwd_sel_e          sel
);
    logic src_live, hit_mem, hit_wb;

    assign src_live = (src != '0);
    assign hit_mem  = src_live && exmem_we && (exmem_rd == src);
    assign hit_wb   = src_live && memwb_we && (memwb_rd == src);

    always_comb begin
        unique case ({hit_mem, hit_wb})
            2'b10, 2'b11: sel = FWD_MEM;
            2'b01:        sel = FWD_WB;
            default:      sel = FWD_RF;
        endcase
    end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_is_load,
    output logic              stall
);
    logic dst_live;

    assign dst_live = ex_is_load && (ex_rd != '0);
    assign stall    = dst_live && ((ex_rd == id_rs) || (ex_rd == id_rt));
endmodule

// File: rtl/hz_flow_ctl.sv
module hz_flow_ctl (
    input  logic stall,
    input  logic br_taken,
    output logic pc_we,
    output logic ifid_we,
    output logic idex_bubble,
    output logic ifid_flush
);
    assign pc_we       = !stall;
    assign ifid_we     = !stall;
    assign idex_bubble = stall;
    assign ifid_flush  = br_taken && !stall;
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
    import hz_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] id_rs,
    input  logic [REG_AW-1:0] id_rt,
    input  logic [REG_AW-1:0] ex_rs,
    input  logic [REG_AW-1:0] ex_rt,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] exmem_rd,
    input  logic              exmem_we,
    input  logic [REG_AW-1:0] memwb_rd,
    input  logic              memwb_we,
    input  logic              id_br_taken,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              pc_we,
    output logic              ifid_we,
    output logic              idex_bubble,
    output logic              ifid_flush
);
    localparam int NSRC = 2;

    logic [REG_AW-1:0] ex_src [NSRC];
    fwd_sel_e          sel    [NSRC];
    logic              stall;

    assign ex_src[0] = ex_rs;
    assign ex_src[1] = ex_rt;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hz_fwd_pick #(.REG_AW(REG_AW)) u_pick (
            .src      (ex_src[g]),
            .exmem_rd (exmem_rd),
            .exmem_we (exmem_we),
            .memwb_rd (memwb_rd),
            .memwb_we (memwb_we),
            .sel      (sel[g])
        );
    end

    assign fwd_a = sel[0];
    assign fwd_b = sel[1];

    hz_load_use #(.REG_AW(REG_AW)) u_lu (
        .id_rs      (id_rs),
        .id_rt      (id_rt),
        .ex_rd      (ex_rd),
        .ex_is_load (ex_is_load),
        .stall      (stall)
    );

    hz_flow_ctl u_flow (
        .stall       (stall),
        .br_taken    (id_br_taken),
        .pc_we       (pc_we),
        .ifid_we     (ifid_we),
        .idex_bubble (idex_bubble),
        .ifid_flush  (ifid_flush)
    );
endmodule

// File: rtl/pipe_hazard_ctl_chk.sv
module pipe_hazard_ctl_chk #(
    parameter int REG_AW = 5
) (
    input logic [REG_AW-1:0] id_rs,
    input logic [REG_AW-1:0] id_rt,
    input logic [REG_AW-1:0] ex_rs,
    input logic [REG_AW-1:0] ex_rt,
    input logic [REG_AW-1:0] ex_rd,
    input logic              ex_is_load,
    input logic [REG_AW-1:0] exmem_rd,
    input logic              exmem_we,
    input logic [REG_AW-1:0] memwb_rd,
    input logic              memwb_we,
    input logic              id_br_taken,
    input logic [1:0]        fwd_a,
    input logic [1:0]        fwd_b,
    input logic              pc_we,
    input logic              ifid_we,
    input logic              idex_bubble,
    input logic              ifid_flush
);
    always_comb begin
        // R2 / R4: a live younger match always selects the exec/mem path
        if (exmem_we && exmem_rd != '0 && exmem_rd == ex_rs)
            a_r2_mem_fwd_a: assert (fwd_a == 2'b10) else $error("R2 fwd_a");
        if (exmem_we && exmem_rd != '0 && exmem_rd == ex_rt)
            a_r4_mem_fwd_b: assert (fwd_b == 2'b10) else $error("R4 fwd_b");
        // R5: register 0 stays on the register file
        if (ex_rs == '0)
            a_r5_zero_a: assert (fwd_a == 2'b00) else $error("R5 fwd_a");
        // R6: no write flags, no forwarding
        if (!exmem_we && !memwb_we)
            a_r6_no_we: assert (fwd_a == 2'b00 && fwd_b == 2'b00) else $error("R6");
        // R7: load-use raises the bubble and freezes fetch
        if (ex_is_load && ex_rd != '0 && (ex_rd == id_rs || ex_rd == id_rt))
            a_r7_stall: assert (idex_bubble && !pc_we && !ifid_we) else $error("R7");
        // R9: flush and bubble never together
        a_r9_no_flush_in_stall: assert (!(ifid_flush && idex_bubble)) else $error("R9");
        // R8: flush only on a taken branch
        if (!id_br_taken)
            a_r8_no_branch: assert (!ifid_flush) else $error("R8");
    end
endmodule

bind pipe_hazard_ctl pipe_hazard_ctl_chk #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/test_pipe_hazard_ctl.sv
module test_pipe_hazard_ctl;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, exmem_rd, memwb_rd;
    logic ex_is_load, exmem_we, memwb_we, id_br_taken;
    logic [1:0] fwd_a, fwd_b;
    logic pc_we, ifid_we, idex_bubble, ifid_flush;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    pipe_hazard_ctl #(.REG_AW(AW)) i_pipe_hazard_ctl (.*);

    function automatic logic [1:0] exp_fwd(input logic [AW-1:0] s);
        if (s != 0 && exmem_we && exmem_rd == s) return 2'b10;
        if (s != 0 && memwb_we && memwb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic bit exp_stall();
        return ex_is_load && ex_rd != 0 && (ex_rd == id_rs || ex_rd == id_rt);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        bit st;
        st = exp_stall();
        chk({req, " fwd_a"}, {6'd0, fwd_a}, {6'd0, exp_fwd(ex_rs)});
        chk({req, " fwd_b"}, {6'd0, fwd_b}, {6'd0, exp_fwd(ex_rt)});
        chk({req, " flow"}, {4'd0, pc_we, ifid_we, idex_bubble, ifid_flush},
            {4'd0, !st, !st, st, id_br_taken && !st});
    endtask

    task automatic apply(input logic [AW-1:0] irs, irt, ers, ert, erd,
                         input logic ld, input logic [AW-1:0] mrd, input logic mwe,
                         input logic [AW-1:0] wrd, input logic wwe, input logic br);
        @(negedge clk);
        id_rs = irs; id_rt = irt; ex_rs = ers; ex_rt = ert; ex_rd = erd;
        ex_is_load = ld; exmem_rd = mrd; exmem_we = mwe;
        memwb_rd = wrd; memwb_we = wwe; id_br_taken = br;
        #1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        apply(0,0,0,0,0,0,0,0,0,0,0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1 quiet state
        apply(1,2,3,4,5,0,6,1,7,1,0);
        chk("R1 fwd_a", {6'd0, fwd_a}, 8'h00);
        chk("R1 fwd_b", {6'd0, fwd_b}, 8'h00);
        chk("R1 flow", {4'd0, pc_we, ifid_we, idex_bubble, ifid_flush}, 8'b1100);
        // R2 exec/mem forward to A
        apply(0,0,3,4,0,0,3,1,0,0,0);
        chk("R2 fwd_a", {6'd0, fwd_a}, 8'h02);
        // R3 mem/wb forward to B
        apply(0,0,3,4,0,0,9,1,4,1,0);
        chk("R3 fwd_b", {6'd0, fwd_b}, 8'h01);
        // R4 both match, younger wins
        apply(0,0,7,7,0,0,7,1,7,1,0);
        chk("R4 fwd_a", {6'd0, fwd_a}, 8'h02);
        chk("R4 fwd_b", {6'd0, fwd_b}, 8'h02);
        // R5 register zero
        apply(0,0,0,0,0,1,0,1,0,1,0);
        chk("R5 fwd", {4'd0, fwd_a, fwd_b}, 8'h00);
        chk("R5 no stall", {7'd0, idex_bubble}, 8'h00);
        // R6 write flag off
        apply(0,0,5,6,0,0,5,0,6,0,0);
        chk("R6 fwd", {4'd0, fwd_a, fwd_b}, 8'h00);
        // R6 with exec/mem off falls back to mem/wb
        apply(0,0,5,5,0,0,5,0,5,1,0);
        chk("R6 fallback", {4'd0, fwd_a, fwd_b}, 8'h05);
        // R7 load-use on rt
        apply(8,9,0,0,9,1,0,0,0,0,0);
        chk("R7 flow", {4'd0, pc_we, ifid_we, idex_bubble, ifid_flush}, 8'b0010);
        // R7 non-load does not stall
        apply(8,9,0,0,9,0,0,0,0,0,0);
        chk("R7 no load", {7'd0, idex_bubble}, 8'h00);
        // R8 taken branch
        apply(1,2,0,0,3,1,0,0,0,0,1);
        chk("R8 flush", {7'd0, ifid_flush}, 8'h01);
        // R9 stall beats flush
        apply(1,2,0,0,1,1,0,0,0,0,1);
        chk("R9 flow", {4'd0, pc_we, ifid_we, idex_bubble, ifid_flush}, 8'b0010);
        // R10 independent selects
        apply(0,0,3,4,0,0,3,1,4,1,0);
        chk("R10 fwd", {4'd0, fwd_a, fwd_b}, 8'h09);
        // random sweep over a small register range (R2-style and R7-style mixes)
        for (int i = 0; i < 3000; i++) begin
            apply(AW'($urandom_range(0,3)), AW'($urandom_range(0,3)),
                  AW'($urandom_range(0,3)), AW'($urandom_range(0,3)),
                  AW'($urandom_range(0,3)), 1'($urandom_range(0,1)),
                  AW'($urandom_range(0,3)), 1'($urandom_range(0,1)),
                  AW'($urandom_range(0,3)), 1'($urandom_range(0,1)),
                  1'($urandom_range(0,1)));
            check_all("R3/R7/R9 random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule